// File: doc/BRIEF.md
# Remote Fault Pattern Detector

This block sits on the recovered serial receive stream of a fibre Ethernet port. It takes one bit per clock, qualified by a valid strobe. It looks for the in-band signal a link partner sends to report a receive problem. That signal is a run of exactly 84 ones closed by a single zero, repeated back to back. When three such patterns arrive in a row, the block raises a fault flag for the link monitoring logic.

A run-length counter tracks the current stretch of ones and saturates one step past the required length, so very long idle runs cannot wrap into a false match. A pattern counter tracks how many matching patterns have arrived in a row. Any zero that closes a run of the wrong length clears that count. A run that grows past the required length also clears it. Ordinary carrier traffic puts short runs between zeros, so it never builds up a count.

Top module: `fefDetector`

## Requirements
- R1: A synchronous reset clears all state. The fault output reads 0 after any reset, including a reset applied while the fault is asserted.
- R2: A valid zero that closes a run of exactly 84 valid ones counts as one pattern. The fault output goes to 1 in the cycle after the clock edge that takes the third consecutive closing zero.
- R3: Only two consecutive patterns leave the fault output at 0.
- R4: A zero that closes a run of 83 or 85 ones clears the pattern count. Three new patterns are then needed before the fault output goes to 1.
- R5: Carrier traffic never counts as a pattern. Here carrier traffic means zeros that are not adjacent, separated by short runs of ones.
- R6: While patterns keep arriving back to back, the fault output stays at 1.
- R7: When the fault output is 1, it stays 1 through 84 ones after the last closing zero. It drops to 0 in the cycle after the edge that takes the 85th one.
- R8: When the fault output is 1, a zero that closes a run of the wrong length drops it to 0 in the next cycle.
- R9: A cycle with bitValid at 0 changes no state and leaves the fault output unchanged, whatever value rxBit has. A pattern with idle cycles between its bits still counts.
- R10: The run counter saturates. A run of 212 ones closed by a zero does not count as a pattern. (212 is the 7-bit wrap of 84.)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| bitValid | input | 1 | rxBit carries a received bit this cycle |
| rxBit | input | 1 | Recovered serial receive bit |
| fefIndicate | output | 1 | Remote fault detected, to the link monitor |

## Verification
The bit on the inputs at a rising edge changes the fault output exactly one cycle later, because the output is decoded straight from the pattern counter register. The bench therefore drives the inputs on falling edges. It checks the output on the falling edge that follows the rising edge which took the last bit of each stimulus segment. For the drop on a long run, it checks the output both after the 84th one and after the 85th one, to pin down the exact cycle.

// File: rtl/fefPkg.sv
package fefPkg;
  // Strobes from control to datapath, decoded once per valid bit.
  typedef struct packed {
    logic incRun;   // advance the run-of-ones counter
    logic clrRun;   // a zero closed the run
    logic hitPat;   // the closed run had the required length
    logic missPat;  // the pattern sequence is broken
  } fefStrobes_t;
endpackage

// File: rtl/fefControl.sv
module fefControl
  import fefPkg::*;
(
  input  logic        bitValid,
  input  logic        rxBit,
  input  logic        runAtLen,
  input  logic        runSat,
  output fefStrobes_t strb
);
  always_comb begin
    strb = '0;
    if (bitValid) begin
      if (rxBit) begin
        strb.incRun  = !runSat;
        // one more one than allowed: the period expired with no pattern end
        strb.missPat = runAtLen;
      end else begin
        strb.clrRun  = 1'b1;
        strb.hitPat  = runAtLen;
        strb.missPat = !runAtLen;
      end
    end
  end
endmodule

// File: rtl/fefDatapath.sv
module fefDatapath
  import fefPkg::*;
#(
  parameter int RUN_LEN = 84,
  parameter int REPEATS = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  fefStrobes_t strb,
  output logic        runAtLen,
  output logic        runSat,
  output logic        patFull
);
  localparam int RUN_MAX = RUN_LEN + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int PAT_W   = $clog2(REPEATS + 1);

  logic [RUN_W-1:0] runCnt;
  logic [PAT_W-1:0] patCnt;

  always_ff @(posedge clk) begin
    if (rst)              runCnt <= '0;
    else if (strb.clrRun) runCnt <= '0;
    else if (strb.incRun) runCnt <= runCnt + RUN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                         patCnt <= '0;
    else if (strb.missPat)           patCnt <= '0;
    else if (strb.hitPat && !patFull) patCnt <= patCnt + PAT_W'(1);
  end

  assign runAtLen = (runCnt == RUN_W'(RUN_LEN));
  assign runSat   = (runCnt == RUN_W'(RUN_MAX));
  assign patFull  = (patCnt == PAT_W'(REPEATS));
endmodule

// File: rtl/fefDetector.sv
module fefDetector
  import fefPkg::*;
#(
  parameter int RUN_LEN = 84,
  parameter int REPEATS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bitValid,
  input  logic rxBit,
  output logic fefIndicate
);
  fefStrobes_t strb;
  logic runAtLen;
  logic runSat;
  logic patFull;

  fefControl u_ctrl (
    .bitValid (bitValid),
    .rxBit    (rxBit),
    .runAtLen (runAtLen),
    .runSat   (runSat),
    .strb     (strb)
  );

  fefDatapath #(.RUN_LEN(RUN_LEN), .REPEATS(REPEATS)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .runAtLen (runAtLen),
    .runSat   (runSat),
    .patFull  (patFull)
  );

  assign fefIndicate = patFull;
endmodule

// File: rtl/fefDetectorChecker.sv
module fefDetectorChecker (
  input logic clk,
  input logic rst,
  input logic bitValid,
  input logic rxBit,
  input logic fefIndicate
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !fefIndicate); // R1

  AST_RISE_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(fefIndicate) |-> $past(bitValid && !rxBit)); // R2

  AST_FALL_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
    $fell(fefIndicate) |-> ($past(bitValid) || $past(rst))); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!bitValid && !rst) |=> $stable(fefIndicate)); // R9

  AST_FALL_ON_WRONG_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($fell(fefIndicate) && !$past(rst) && !$past(rxBit)) |-> $past(bitValid)); // R8
endmodule

bind fefDetector fefDetectorChecker u_chk (
  .clk         (clk),
  .rst         (rst),
  .bitValid    (bitValid),
  .rxBit       (rxBit),
  .fefIndicate (fefIndicate)
);

// File: tb/fefDetector_bench.sv
module fefDetector_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitValid = 1'b0;
  logic rxBit = 1'b0;
  logic fefIndicate;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  fefDetector u_fefDetector (
    .clk(clk), .rst(rst), .bitValid(bitValid), .rxBit(rxBit), .fefIndicate(fefIndicate)
  );

  // Entry: [9:2] ones to send, [1] close with a zero, [0] expected fault output afterwards.
  localparam int NVEC = 24;
  localparam logic [9:0] VEC [0:NVEC-1] = '{
    {8'd84,  1'b1, 1'b0},  // R2 first pattern
    {8'd84,  1'b1, 1'b0},  // R3 two patterns only
    {8'd84,  1'b1, 1'b1},  // R2 third pattern raises fault
    {8'd84,  1'b1, 1'b1},  // R6 fault persists
    {8'd83,  1'b1, 1'b0},  // R8 short run drops fault, R4
    {8'd84,  1'b1, 1'b0},  // R4 recount 1
    {8'd84,  1'b1, 1'b0},  // R4 recount 2
    {8'd85,  1'b1, 1'b0},  // R4 long run resets count
    {8'd84,  1'b1, 1'b0},  // R4
    {8'd84,  1'b1, 1'b0},  // R4
    {8'd84,  1'b1, 1'b1},  // R4 three fresh patterns
    {8'd5,   1'b1, 1'b0},  // R5 carrier zero, R8 drop
    {8'd30,  1'b1, 1'b0},  // R5 carrier zero
    {8'd2,   1'b1, 1'b0},  // R5 carrier zero
    {8'd84,  1'b1, 1'b0},  // R5 carrier never counted
    {8'd84,  1'b1, 1'b0},  // R5
    {8'd84,  1'b1, 1'b1},  // R2
    {8'd84,  1'b0, 1'b1},  // R7 84 ones still within period
    {8'd1,   1'b0, 1'b0},  // R7 85th one drops fault
    {8'd0,   1'b1, 1'b0},  // R7 zero after long run
    {8'd212, 1'b1, 1'b0},  // R10 saturated run does not match
    {8'd84,  1'b1, 1'b0},  // R10
    {8'd84,  1'b1, 1'b0},  // R10 would be third match if wrapped
    {8'd84,  1'b1, 1'b1}   // R10 third genuine match
  };

  task automatic check(input logic exp, input string req);
    checks++;
    if (fefIndicate !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, fefIndicate, exp);
    end
  endtask

  task automatic sendBit(input logic b, input int gap);
    @(negedge clk);
    bitValid = 1'b1;
    rxBit = b;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      bitValid = 1'b0;
      rxBit = g[0];
    end
  endtask

  task automatic sendRun(input int ones, input logic endZero, input int gap);
    for (int i = 0; i < ones; i++) sendBit(1'b1, gap);
    if (endZero) sendBit(1'b0, gap);
    @(negedge clk);
    bitValid = 1'b0;
    rxBit = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    bitValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    doReset();
    check(1'b0, "R1 reset state");

    for (int v = 0; v < NVEC; v++) begin
      sendRun(int'(VEC[v][9:2]), VEC[v][1], 0);
      check(VEC[v][0], $sformatf("vector %0d", v));
    end

    // R1: reset while the fault is asserted
    doReset();
    for (int k = 0; k < 3; k++) sendRun(84, 1'b1, 0);
    check(1'b1, "R1 fault set before reset");
    doReset();
    check(1'b0, "R1 reset clears fault");
    sendRun(84, 1'b1, 0);
    check(1'b0, "R1 count cleared by reset");

    // R9: idle cycles interleaved with garbage rxBit do not disturb patterns
    doReset();
    for (int k = 0; k < 3; k++) sendRun(84, 1'b1, 2);
    check(1'b1, "R9 gapped patterns counted");
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      bitValid = 1'b0;
      rxBit = k[0];
    end
    @(negedge clk);
    check(1'b1, "R9 idle holds fault");

    // R7: exact drop point with idle gaps
    sendRun(84, 1'b0, 1);
    check(1'b1, "R7 84 ones keep fault");
    sendRun(1, 1'b0, 1);
    check(1'b0, "R7 85th one clears fault");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule